// File: doc/BRIEF.md
# Synchronous Serial Frame Transmitter

This block is the transmit channel of a synchronous serial port that sends one word per frame. The bit clock and the frame sync come in from outside as levels. The block samples them on its own system clock and acts on their rising edges. When a frame starts, a shift register loads one word and drives it onto a serial data pin, most significant bit first. The pin carries an output-enable, so the line is released outside the word window.

Software supplies data in one of two ways. It can write a single holding register, or, when queueing is switched on, it can push words into an 8-entry FIFO that has a programmable watermark. Three flags report the channel's state: holding-register empty, FIFO below watermark, and underrun. One of the two empty flags is routed to an interrupt request, depending on the mode. If a frame starts and no fresh data is available, the previous word is sent again and the underrun flag is set. The flag clears only when a status read is followed by a data write.

The control state machine has two states. IDLE keeps the pin released and takes the transition IDLE->SHIFT on a frame start while the channel is enabled. SHIFT drives bits and has three transitions. SHIFT->SHIFT is taken on each bit-clock edge before the last bit. SHIFT->SHIFT with a reload is taken when a new frame start coincides with the edge that ends the word. SHIFT->IDLE is taken on the edge after the last bit otherwise.

Top module: `sync_frame_tx`

## Requirements
- R1: A rising edge of `fsync`, seen together with a rising edge of `bclk`, starts a word when `tx_en` is 1. One system clock later `sd_oe` is 1 and `sd_out` shows the word's most significant bit.
- R2: Each later rising edge of `bclk` puts the next lower bit on `sd_out`, so the word is sent most significant bit first.
- R3: `wl_sel` chooses the word length: 0 = 8 bits, 1 = 10, 2 = 12, 3 = 16. Only the low word-length bits of the written data are sent, and the upper bits are ignored.
- R4: On the `bclk` rising edge that follows the last bit, `sd_oe` goes to 0 and stays 0 until the next frame start. While `sd_oe` is 0, `sd_out` is 0.
- R5: With `fifo_en` = 0, a write loads the holding register and clears `tde`. A frame start that takes the holding register sets `tde`. After reset, `tde` is 1.
- R6: With `fifo_en` = 1, each write pushes into the FIFO and each frame start pops the oldest entry. Words go out in write order. A write to a full FIFO (`fifo_level` = 8) is dropped.
- R7: `tfe` is 1 exactly when `fifo_en` is 1 and `fifo_level` is below `wmark`.
- R8: `irq` equals `irq_en` AND (`tfe` when `fifo_en` = 1, otherwise `tde`).
- R9: A frame start with no fresh data sets `tue` and sends the previous word again. No fresh data means `tde` = 1 in holding mode, or an empty FIFO in FIFO mode.
- R10: `tue` clears only on a write that follows a `stat_rd` pulse taken while `tue` was 1. A write alone leaves `tue` set.
- R11: With `tx_en` = 0, no frame starts, so `sd_oe` stays 0 and no data is consumed. Clearing `tx_en` during a word lets that word finish.
- R12: A frame sync rising edge in the middle of a word is ignored, and the word completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock level |
| fsync | input | 1 | Frame sync level |
| tx_en | input | 1 | Channel enable |
| fifo_en | input | 1 | 1 = data comes from the FIFO |
| irq_en | input | 1 | Interrupt enable |
| wl_sel | input | 2 | Word length select |
| wmark | input | 4 | FIFO watermark level |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 16 | Data written |
| stat_rd | input | 1 | Status read strobe |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |
| tde | output | 1 | Holding register empty |
| tfe | output | 1 | FIFO below watermark |
| tue | output | 1 | Transmit underrun |
| irq | output | 1 | Interrupt request |
| fifo_level | output | 4 | FIFO fill level |

## Verification
If the bit counter is wrong, `sd_oe` drops one bit-clock edge too early or too late. That error shows up within the first word. If the state machine fails to return to IDLE, frame starts are missed, and `sd_oe` stays high past the word window. If the FIFO pointers or the level are wrong, words come out in the wrong order and `fifo_level`, `tfe` or `irq` mismatch at the next frame. If the underrun bookkeeping is wrong, the repeated word is different or `tue` changes at the wrong write. Each of these faults appears at the ports within one frame of the stimulus that exposes it.

// File: rtl/tx_pkg.sv
package tx_pkg;
    typedef enum logic {ST_IDLE, ST_SHIFT} tx_state_e;

    function automatic int wl_of(input logic [1:0] sel);
        unique case (sel)
            2'd0: return 8;
            2'd1: return 10;
            2'd2: return 12;
            default: return 16;
        endcase
    endfunction
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    always_comb begin
        push_ok = push && (level != LW'(DEPTH));
        pop_ok  = pop && (level != '0);
        head    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            level <= level + LW'(push_ok) - LW'(pop_ok);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    assert_no_pop_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> level != '0);
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import tx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bclk,
    input  logic          fsync,
    input  logic          tx_en,
    input  logic [1:0]    wl_sel,
    input  logic [DW-1:0] word_i,
    output logic          load_o,
    output logic          sd_out,
    output logic          sd_oe
);
    localparam int CW = $clog2(DW+1);

    tx_state_e     state, nxt;
    logic          bclk_q, fs_q;
    logic          bclk_rise, fs_rise, last_bit;
    logic [DW-1:0] sreg;
    logic [CW-1:0] cnt, wl_q;

    always_comb begin
        bclk_rise = bclk && !bclk_q;
        fs_rise   = fsync && !fs_q;
        last_bit  = (state == ST_SHIFT) && bclk_rise && (cnt == wl_q);
        load_o    = fs_rise && bclk_rise && tx_en && ((state == ST_IDLE) || last_bit);
        nxt       = state;
        unique case (state)
            ST_IDLE:  nxt = load_o ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: if (last_bit) nxt = load_o ? ST_SHIFT : ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            fs_q   <= 1'b0;
            sreg   <= '0;
            cnt    <= '0;
            wl_q   <= '0;
        end else begin
            bclk_q <= bclk;
            fs_q   <= fsync;
            if (load_o) begin
                sreg <= word_i << (DW - wl_of(wl_sel));
                cnt  <= CW'(1);
                wl_q <= CW'(wl_of(wl_sel));
            end else if ((state == ST_SHIFT) && bclk_rise && !last_bit) begin
                sreg <= sreg << 1;
                cnt  <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        sd_oe  = (state == ST_SHIFT);
        sd_out = sd_oe ? sreg[DW-1] : 1'b0;
    end

    assert_start_on_fs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_oe) |-> $past(fsync && tx_en));
    assert_oe_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> (cnt != '0 && cnt <= wl_q));
endmodule

// File: rtl/sync_frame_tx.sv
module sync_frame_tx #(
    parameter int DW    = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bclk,
    input  logic                       fsync,
    input  logic                       tx_en,
    input  logic                       fifo_en,
    input  logic                       irq_en,
    input  logic [1:0]                 wl_sel,
    input  logic [$clog2(DEPTH+1)-1:0] wmark,
    input  logic                       wr_en,
    input  logic [DW-1:0]              wr_data,
    input  logic                       stat_rd,
    output logic                       sd_out,
    output logic                       sd_oe,
    output logic                       tde,
    output logic                       tfe,
    output logic                       tue,
    output logic                       irq,
    output logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    logic [DW-1:0] hold_q, last_q, head, word_sel;
    logic          load, fresh, fifo_empty, rd_armed;

    tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(wr_en && fifo_en), .push_data(wr_data),
        .pop(load && fifo_en && !fifo_empty),
        .head(head), .level(fifo_level)
    );

    tx_frame_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .tx_en(tx_en),
        .wl_sel(wl_sel), .word_i(word_sel), .load_o(load),
        .sd_out(sd_out), .sd_oe(sd_oe)
    );

    always_comb begin
        fifo_empty = (fifo_level == '0);
        fresh      = fifo_en ? !fifo_empty : !tde;
        word_sel   = !fresh ? last_q : (fifo_en ? head : hold_q);
        tfe        = fifo_en && (fifo_level < wmark);
        irq        = irq_en && (fifo_en ? tfe : tde);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            last_q   <= '0;
            tde      <= 1'b1;
            tue      <= 1'b0;
            rd_armed <= 1'b0;
        end else begin
            if (stat_rd) rd_armed <= tue;
            if (wr_en && rd_armed) begin
                tue      <= 1'b0;
                rd_armed <= 1'b0;
            end
            if (load) begin
                last_q <= word_sel;
                if (!fifo_en) tde <= 1'b1;
                if (!fresh)   tue <= 1'b1;
            end
            if (wr_en && !fifo_en) begin
                hold_q <= wr_data;
                tde    <= 1'b0;
            end
        end
    end

    assert_tue_on_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tue) |-> $past(load));
    assert_tde_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tde) |-> $past(wr_en && !fifo_en));
    assert_tue_clear_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tue) |-> $past(wr_en));
endmodule

// File: tb/test_sync_frame_tx.sv
`timescale 1ns/1ps
module test_sync_frame_tx;
    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk = 0, fsync = 0, tx_en = 0, fifo_en = 0, irq_en = 0;
    logic [1:0] wl_sel = 2'd3;
    logic [3:0] wmark = 4'd2;
    logic wr_en = 0, stat_rd = 0;
    logic [15:0] wr_data = '0;
    logic sd_out, sd_oe, tde, tfe, tue, irq;
    logic [3:0] fifo_level;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_frame_tx i_sync_frame_tx (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .tx_en(tx_en),
        .fifo_en(fifo_en), .irq_en(irq_en), .wl_sel(wl_sel), .wmark(wmark),
        .wr_en(wr_en), .wr_data(wr_data), .stat_rd(stat_rd),
        .sd_out(sd_out), .sd_oe(sd_oe), .tde(tde), .tfe(tfe), .tue(tue),
        .irq(irq), .fifo_level(fifo_level)
    );

    // each entry: word length select, written data
    localparam logic [17:0] VEC [6] = '{
        {2'd0, 16'hA5C3}, {2'd1, 16'hFFFF}, {2'd2, 16'h1234},
        {2'd3, 16'h8001}, {2'd0, 16'h7E01}, {2'd3, 16'h5A5A}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic fs);
        @(negedge clk); bclk = 1; fsync = fs;
        @(negedge clk);
        @(negedge clk); bclk = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic srd();
        @(negedge clk); stat_rd = 1;
        @(negedge clk); stat_rd = 0;
    endtask

    task automatic frame(input int wl, input int fs_at, input bit dis,
                         output logic [15:0] w, output int oe_bad);
        w = '0; oe_bad = 0;
        for (int i = 0; i < wl; i++) begin
            tick(i == 0 || i == fs_at);
            if (i == 0 && dis) tx_en = 0;
            if (!sd_oe) oe_bad++;
            w = {w[14:0], sd_out};
        end
        tick(0);
        if (sd_oe) oe_bad++;
    endtask

    function automatic int wl_bits(input logic [1:0] s);
        return (s == 0) ? 8 : (s == 1) ? 10 : (s == 2) ? 12 : 16;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R4 reset oe", sd_oe, 0);
        chk("R5 reset tde", tde, 1);
        chk("R9 reset tue", tue, 0);
        chk("R8 reset irq", irq, 0);

        // R11: disabled channel ignores frame sync
        wr(16'hBEEF);
        tick(1); tick(0);
        chk("R11 no start when disabled", sd_oe, 0);
        chk("R11 data not consumed", tde, 0);
        tx_en = 1;

        // vector table: R1 R2 R3 R4 R5
        foreach (VEC[k]) begin
            wl_sel = VEC[k][17:16];
            wr(VEC[k][15:0]);
            frame(wl_bits(wl_sel), -1, 0, w, bad);
            chk("R2/R3 word", w, VEC[k][15:0] & ((32'd1 << wl_bits(wl_sel)) - 1));
            chk("R1/R4 oe window", bad, 0);
            chk("R5 tde after load", tde, 1);
        end
        wl_sel = 2'd3;

        // R8 non-FIFO interrupt
        irq_en = 1;
        @(negedge clk);
        chk("R8 irq on tde", irq, 1);
        wr(16'h1111);
        chk("R5 tde cleared", tde, 0);
        chk("R8 irq cleared", irq, 0);

        // R9 underrun / R10 clear sequence
        frame(16, -1, 0, w, bad);
        chk("R9 normal word", w, 16'h1111);
        chk("R9 no underrun yet", tue, 0);
        frame(16, -1, 0, w, bad);
        chk("R9 underrun set", tue, 1);
        chk("R9 resend previous", w, 16'h1111);
        wr(16'h2222);
        chk("R10 write alone keeps tue", tue, 1);
        srd();
        wr(16'h3333);
        chk("R10 read+write clears tue", tue, 0);

        // R12 mid-word frame sync ignored
        frame(16, 5, 0, w, bad);
        chk("R12 word intact", w, 16'h3333);
        chk("R12 oe window", bad, 0);

        // R11 disable mid-word
        wr(16'hC0DE);
        frame(16, -1, 1, w, bad);
        chk("R11 word finishes", w, 16'hC0DE);
        chk("R11 oe window", bad, 0);
        tick(1); tick(0);
        chk("R11 stopped", sd_oe, 0);
        chk("R11 no underrun when off", tue, 0);
        tx_en = 1;

        // FIFO mode: R6 R7 R8 R9
        fifo_en = 1;
        @(negedge clk);
        chk("R7 tfe empty", tfe, 1);
        chk("R8 irq on tfe", irq, 1);
        wr(16'hA001); wr(16'hA002); wr(16'hA003);
        chk("R6 level", fifo_level, 3);
        chk("R7 tfe above mark", tfe, 0);
        chk("R8 irq low", irq, 0);
        frame(16, -1, 0, w, bad);
        chk("R6 order 1", w, 16'hA001);
        chk("R7 tfe at mark", tfe, 0);
        frame(16, -1, 0, w, bad);
        chk("R6 order 2", w, 16'hA002);
        chk("R7 tfe below mark", tfe, 1);
        chk("R8 irq fifo", irq, 1);
        frame(16, -1, 0, w, bad);
        chk("R6 order 3", w, 16'hA003);
        chk("R9 no underrun", tue, 0);
        frame(16, -1, 0, w, bad);
        chk("R9 fifo underrun", tue, 1);
        chk("R9 fifo resend", w, 16'hA003);
        srd();
        wr(16'hB000);
        chk("R10 cleared fifo", tue, 0);
        for (int i = 1; i <= 8; i++) wr(16'hB000 + 16'(i));
        chk("R6 full drop", fifo_level, 8);
        frame(16, -1, 0, w, bad);
        chk("R6 head after full", w, 16'hB000);
        chk("R6 level after pop", fifo_level, 7);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule